// File: doc/BRIEF.md
# Linear-Function Offload Unit

This block is a small memory-mapped accelerator that a processor invokes to evaluate y = m*x + b. Software writes the operands through a simple register read/write port, pulses a start strobe, and collects the result once the unit reports completion. All arithmetic is unsigned and taken modulo 2^DW.

Operand state is split by lifetime. The slope is written once during setup and persists across every invocation. The input value and the offset are written before each call. The result is read after each call. An accumulator adds up every result so that software can read the total once after the last call.

Software can observe completion in three ways. It can wait the fixed two-cycle latency. It can poll a sticky done bit. It can enable an interrupt output that mirrors done. The intermediate product is held inside the unit and is never visible through the register port.

Top module: `linfn_offload`

## Requirements
- R1: After reset, done, busy and irq are 0, and every register reads 0.
- R2: After a call completes, address 4 (result) reads (m*x + b) mod 2^DW. Addresses 6 and 7 read 0, so the product is never exposed.
- R3: A go pulse accepted while idle makes busy (CTRL bit 1) read 1 for exactly two cycles. done then reads 1 on the second cycle after the accepting edge.
- R4: done is sticky. It stays 1 until a CTRL write with bit 1 set, or until the next accepted go. Either one clears it one cycle later.
- R5: irq equals done while the interrupt-enable bit (CTRL bit 2, written and read back at that position) is 1. While that bit is 0, irq is 0.
- R6: The slope (address 1) keeps its value across calls. Calls that rewrite only x (address 2) and b (address 3) use the stored slope.
- R7: The accumulator (address 5) holds the sum, mod 2^DW, of every result produced since reset or since the last soft clear.
- R8: A CTRL write with bit 3 set zeroes the accumulator one cycle later and leaves the slope unchanged.
- R9: While busy, writes to addresses 1 to 3 are ignored and go is dropped. A dropped go produces no extra completion and no extra accumulation.
- R10: CTRL (address 0) reads done in bit 0, busy in bit 1 and the interrupt enable in bit 2. Addresses 1 to 3 read back the last value accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data for addr, combinational |
| go | input | 1 | Start strobe, taken only while idle |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request, done gated by enable |

## Verification
The edge that accepts a go is called E0. Busy is visible after E0 and after E1. done, the result and the updated accumulator are all visible after E2. The bench drives inputs on falling edges and samples each value at the falling edge that follows the rising edge it is due on. It checks that done is still low after E1, so the fixed latency is pinned from both sides. Clear-done, soft-clear and go-clears-done each take effect one edge after the write or strobe, and are checked at the next falling edge. Writes and go pulses issued while busy are followed by readback and by a wait of several idle cycles, which shows that neither the operands nor the accumulator moved.

// File: rtl/linfn_pkg.sv
package linfn_pkg;
    localparam int unsigned AW = 3;
    typedef logic [AW-1:0] addr_t;

    localparam addr_t A_CTRL  = 3'd0;
    localparam addr_t A_SLOPE = 3'd1;
    localparam addr_t A_XIN   = 3'd2;
    localparam addr_t A_BIAS  = 3'd3;
    localparam addr_t A_YOUT  = 3'd4;
    localparam addr_t A_ACC   = 3'd5;

    localparam int CB_DONE = 0;
    localparam int CB_BUSY = 1;
    localparam int CB_IEN  = 2;
    localparam int CB_SCLR = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MUL  = 2'd1,
        PH_ADD  = 2'd2
    } phase_e;
endpackage

// File: rtl/linfn_regs.sv
module linfn_regs
    import linfn_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  addr_t         addr,
    input  logic [DW-1:0] wr_data,
    input  logic          busy,
    input  logic          done,
    input  logic [DW-1:0] y,
    input  logic [DW-1:0] acc,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] slope,
    output logic [DW-1:0] xin,
    output logic [DW-1:0] bias,
    output logic          irq_en,
    output logic          clr_done,
    output logic          soft_clr
);
    typedef struct packed {
        logic [DW-1:0] slope;
        logic [DW-1:0] xin;
        logic [DW-1:0] bias;
        logic          ien;
    } regs_t;

    regs_t r_d, r_q;
    logic  ctrl_wr;
    logic  opnd_ok;

    always_comb begin
        r_d      = r_q;
        ctrl_wr  = wr_en && (addr == A_CTRL);
        opnd_ok  = wr_en && !busy;
        clr_done = ctrl_wr && wr_data[CB_DONE+1];
        soft_clr = ctrl_wr && wr_data[CB_SCLR];
        if (ctrl_wr)                     r_d.ien   = wr_data[CB_IEN];
        if (opnd_ok && addr == A_SLOPE)  r_d.slope = wr_data;
        if (opnd_ok && addr == A_XIN)    r_d.xin   = wr_data;
        if (opnd_ok && addr == A_BIAS)   r_d.bias  = wr_data;

        rd_data = '0;
        case (addr)
            A_CTRL: begin
                rd_data[CB_DONE] = done;
                rd_data[CB_BUSY] = busy;
                rd_data[CB_IEN]  = r_q.ien;
            end
            A_SLOPE: rd_data = r_q.slope;
            A_XIN:   rd_data = r_q.xin;
            A_BIAS:  rd_data = r_q.bias;
            A_YOUT:  rd_data = y;
            A_ACC:   rd_data = acc;
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign slope  = r_q.slope;
    assign xin    = r_q.xin;
    assign bias   = r_q.bias;
    assign irq_en = r_q.ien;

    // R9
    busy_slope_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SLOPE && busy) |=> $stable(r_q.slope));
    // R9
    busy_xin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_XIN && busy) |=> $stable(r_q.xin));
    // R6
    slope_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_SLOPE) |=> $stable(r_q.slope));
endmodule

// File: rtl/linfn_ctrl.sv
module linfn_ctrl
    import linfn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic clr_done,
    output logic busy,
    output logic done,
    output logic mul_en,
    output logic add_en
);
    typedef struct packed {
        phase_e ph;
        logic   done;
    } ctl_t;

    ctl_t c_d, c_q;
    logic start;

    always_comb begin
        c_d   = c_q;
        start = go && (c_q.ph == PH_IDLE);
        if (clr_done) c_d.done = 1'b0;
        case (c_q.ph)
            PH_IDLE: if (go) begin
                c_d.ph   = PH_MUL;
                c_d.done = 1'b0;
            end
            PH_MUL: c_d.ph = PH_ADD;
            PH_ADD: begin
                c_d.ph   = PH_IDLE;
                c_d.done = 1'b1;
            end
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{ph: PH_IDLE, done: 1'b0};
        else        c_q <= c_d;
    end

    assign busy   = (c_q.ph != PH_IDLE);
    assign done   = c_q.done;
    assign mul_en = (c_q.ph == PH_MUL);
    assign add_en = (c_q.ph == PH_ADD);

    // R3
    fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.done) |-> $past(start, 3));
    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R4
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.done && !clr_done && !start) |=> c_q.done);
    // R9
    busy_go_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && go) |=> (c_q.ph == PH_IDLE));
endmodule

// File: rtl/linfn_dp.sv
module linfn_dp #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mul_en,
    input  logic          add_en,
    input  logic          soft_clr,
    input  logic [DW-1:0] slope,
    input  logic [DW-1:0] xin,
    input  logic [DW-1:0] bias,
    output logic [DW-1:0] y,
    output logic [DW-1:0] acc
);
    typedef struct packed {
        logic [DW-1:0] prod;
        logic [DW-1:0] y;
        logic [DW-1:0] acc;
    } dp_t;

    dp_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (mul_en) d_d.prod = slope * xin;
        if (add_en) begin
            d_d.y   = d_q.prod + bias;
            d_d.acc = d_q.acc + d_d.y;
        end
        if (soft_clr) d_d.acc = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign y   = d_q.y;
    assign acc = d_q.acc;

    // R8
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (d_q.acc == '0));
    // R7
    acc_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_en && !soft_clr) |=> $stable(d_q.acc));
endmodule

// File: rtl/linfn_offload.sv
module linfn_offload
    import linfn_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          go,
    output logic          done,
    output logic          irq
);
    logic [DW-1:0] slope, xin, bias, y, acc;
    logic          busy, irq_en, clr_done, soft_clr, mul_en, add_en;

    linfn_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .busy(busy), .done(done), .y(y), .acc(acc),
        .rd_data(rd_data), .slope(slope), .xin(xin), .bias(bias),
        .irq_en(irq_en), .clr_done(clr_done), .soft_clr(soft_clr)
    );

    linfn_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .clr_done(clr_done),
        .busy(busy), .done(done), .mul_en(mul_en), .add_en(add_en)
    );

    linfn_dp #(.DW(DW)) u_dp (
        .clk(clk), .rst_n(rst_n), .mul_en(mul_en), .add_en(add_en),
        .soft_clr(soft_clr), .slope(slope), .xin(xin), .bias(bias),
        .y(y), .acc(acc)
    );

    assign irq = done && irq_en;

    // R5
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
endmodule

// File: tb/test_linfn_offload.sv
module test_linfn_offload;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          go = 1'b0;
    logic          done, irq;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] m_mdl, acc_mdl;

    always #2 clk = ~clk;

    linfn_offload #(.DW(DW)) i_linfn_offload (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .go(go), .done(done), .irq(irq)
    );

    function automatic logic [DW-1:0] f_lin(logic [DW-1:0] m, logic [DW-1:0] x, logic [DW-1:0] b);
        return m * x + b;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [DW-1:0] d);
        addr = a;
        #0.5;
        d = rd_data;
    endtask

    // go accepted at E0; returns at negedge after E2 with done due
    task automatic call_and_check(logic [DW-1:0] x, logic [DW-1:0] b);
        logic [DW-1:0] v;
        logic [DW-1:0] ey;
        wr(3'd2, x);
        wr(3'd3, b);
        ey = f_lin(m_mdl, x, b);
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        rd(3'd0, v);
        check("R3 busy after E0", {30'd0, v[1], done}, {30'd0, 1'b1, 1'b0});
        @(negedge clk);
        rd(3'd0, v);
        check("R3 busy after E1, done low", {30'd0, v[1], done}, {30'd0, 1'b1, 1'b0});
        @(negedge clk);
        rd(3'd0, v);
        check("R3 done after E2", {30'd0, v[1], done}, {30'd0, 1'b0, 1'b1});
        acc_mdl = acc_mdl + ey;
        rd(3'd4, v);
        check("R2 result", 32'(v), 32'(ey));
        rd(3'd5, v);
        check("R7 accumulator", 32'(v), 32'(acc_mdl));
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] acc_save;
        void'($urandom(32'd1234));
        m_mdl = '0; acc_mdl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 done/irq", {30'd0, done, irq}, 32'd0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 register zero", 32'(v), 32'd0);
        end

        // R10 readback of operands
        m_mdl = 16'd3;
        wr(3'd1, m_mdl);
        wr(3'd2, 16'h1234);
        wr(3'd3, 16'h00ff);
        rd(3'd1, v); check("R10 slope readback", 32'(v), 32'd3);
        rd(3'd2, v); check("R10 xin readback", 32'(v), 32'h1234);
        rd(3'd3, v); check("R10 bias readback", 32'(v), 32'h00ff);

        // directed: basic, wrap-around
        call_and_check(16'd5, 16'd7);
        m_mdl = 16'hffff; wr(3'd1, m_mdl);
        call_and_check(16'hffff, 16'hffff);
        rd(3'd6, v); check("R2 no product at 6", 32'(v), 32'd0);
        rd(3'd7, v); check("R2 no product at 7", 32'(v), 32'd0);

        // R6: slope retained across calls that only rewrite x and b
        m_mdl = 16'd11; wr(3'd1, m_mdl);
        for (int i = 0; i < 5; i++) call_and_check(16'($urandom), 16'($urandom));
        rd(3'd1, v); check("R6 slope retained", 32'(v), 32'd11);

        // R4: done sticky, clear by CTRL bit 1
        repeat (4) @(negedge clk);
        check("R4 done sticky", {31'd0, done}, 32'd1);
        wr(3'd0, 16'h0002);
        check("R4 clear-done write", {31'd0, done}, 32'd0);

        // R4: next go clears done
        call_and_check(16'd1, 16'd2);
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        check("R4 go clears done", {31'd0, done}, 32'd0);
        repeat (2) @(negedge clk);
        acc_mdl = acc_mdl + f_lin(m_mdl, 16'd1, 16'd2);
        rd(3'd5, v); check("R7 repeated call acc", 32'(v), 32'(acc_mdl));

        // R5: interrupt enable
        wr(3'd0, 16'h0004);
        rd(3'd0, v); check("R10 ien readback", 32'(v), 32'h0005);
        check("R5 irq with enable", {31'd0, irq}, 32'd1);
        wr(3'd0, 16'h0006);
        check("R5 irq low after clear", {31'd0, irq}, 32'd0);
        call_and_check(16'd9, 16'd9);
        check("R5 irq follows done", {31'd0, irq}, 32'd1);
        wr(3'd0, 16'h0000);
        check("R5 irq masked", {30'd0, done, irq}, 32'h2);

        // R9: writes and go while busy
        @(negedge clk); go = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd2; wr_data = 16'h7777;
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd1; wr_data = 16'h5555;
        @(negedge clk);
        wr_en = 1'b0; go = 1'b0;
        acc_mdl = acc_mdl + f_lin(m_mdl, 16'd9, 16'd9);
        rd(3'd4, v); check("R9 result uses pre-busy x", 32'(v), 32'(f_lin(m_mdl, 16'd9, 16'd9)));
        repeat (4) @(negedge clk);
        rd(3'd5, v); check("R9 single accumulation", 32'(v), 32'(acc_mdl));
        rd(3'd2, v); check("R9 xin unchanged", 32'(v), 32'd9);
        rd(3'd1, v); check("R9 slope unchanged", 32'(v), 32'(m_mdl));
        rd(3'd0, v); check("R9 no extra run", 32'(v), 32'h1);

        // R8: soft clear
        acc_save = acc_mdl;
        check("R8 acc nonzero before", 32'(acc_save != 0), 32'd1);
        wr(3'd0, 16'h0008);
        acc_mdl = '0;
        rd(3'd5, v); check("R8 acc cleared", 32'(v), 32'd0);
        rd(3'd1, v); check("R8 slope kept", 32'(v), 32'(m_mdl));

        // random phase
        for (int i = 0; i < 40; i++) begin
            if (($urandom % 4) == 0) begin
                m_mdl = 16'($urandom);
                wr(3'd1, m_mdl);
            end
            call_and_check(16'($urandom), 16'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule